// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word of one root hub port in a USB 3 host controller. Software reads the word on `rd_data` and writes it with a one-cycle `wr_en` strobe carrying `wr_data`. The word contains seven change flags that software clears by writing 1, four plain read/write enable bits, a port-reset trigger and a 4-bit link state field. Writes to the link state are filtered: only a real move into U0 or an upward move into U3 is accepted.

A write with the reset trigger set does nothing except send a single-cycle request to an external port-reset handler. Hardware events such as a connect change set their flags through a separate set port. A newly raised flag produces a port-change event request toward the event generator, and only while the controller run flag is high.

Top module: `port_status_reg`

## Requirements
- R1: A write with bit 4 (reset trigger) set drives `reset_req` high for exactly the cycle after the write edge. That write changes no flag, no link state and no enable bit.
- R2: The change flags sit in bits 17..23, in this order: connect, enable, warm reset, over-current, reset done, link state, config error. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R3: The link state is bits 8:5. It is written only when bit 16 (link write strobe) is 1 in the same write. Otherwise it keeps its value.
- R4: A requested state U0 (0) is applied only when the current state is not 0. When it is applied, it also sets the link state change flag (bit 22).
- R5: A requested state U3 (3) is applied only when the current state is numerically below 3.
- R6: A requested state of Resume (15), or of any value other than 0 or 3, leaves the link state unchanged and raises no indication.
- R7: Bit 9 (power) and bits 25..27 (wake enables) take the written value on every non-reset write. Bits 4 and 16 and all unused bits read as 0.
- R8: `hw_set[i]` sets flag i. When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: A set request (hardware, or the flag from R4) signals a change only if at least one requested flag is clear after that cycle's software clears. The event request is then a one-cycle pulse on `event_req` in the cycle after the register update, which is the second edge after the request.
- R10: A change raises `event_req` only if `run` is high in the cycle of the request.
- R11: After reset the link state reads 5, every other bit reads 0, and `reset_req` and `event_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| hw_set | input | 7 | Hardware change-flag set requests |
| run | input | 1 | Controller run flag |
| rd_data | output | 32 | Current register value |
| reset_req | output | 1 | One-cycle port reset request |
| event_req | output | 1 | One-cycle port change event request |

## Verification
The hardest case to produce is a hardware set meeting a software clear of the same flag in one cycle, alongside the rule that decides the notification from the flags left after the clear. The bench drives `hw_set` and a clearing write on the same negative edge. It expects the flag to remain set and an event to be raised. Separate steps cover a reset write that also carries a U0 request and a clear, and a U0 request that is refused because the link is already in U0.

// File: rtl/port_status_pkg.sv
package port_status_pkg;
  localparam int DATA_W   = 32;
  localparam int PLS_W    = 4;
  localparam int PLS_LSB  = 5;
  localparam int PR_BIT   = 4;
  localparam int PP_BIT   = 9;
  localparam int LWS_BIT  = 16;
  localparam int NFLAGS   = 7;
  localparam int FLAG_LSB = 17;
  localparam int PLC_IDX  = 5;
  localparam int WEN_W    = 3;
  localparam int WEN_LSB  = 25;

  localparam logic [PLS_W-1:0] LS_U0 = 4'd0;
  localparam logic [PLS_W-1:0] LS_U3 = 4'd3;

  // A requested link state is taken only on a real entry into U0 or an upward step into U3.
  function automatic logic ls_accept(input logic [PLS_W-1:0] cur, input logic [PLS_W-1:0] req);
    return ((req == LS_U0) && (cur != LS_U0)) || ((req == LS_U3) && (cur < LS_U3));
  endfunction

  // A change is new when some requested flag is not already set.
  function automatic logic fresh_change(input logic [NFLAGS-1:0] req, input logic [NFLAGS-1:0] cur);
    return |(req & ~cur);
  endfunction
endpackage

// File: rtl/link_state_ctl.sv
module link_state_ctl
  import port_status_pkg::*;
#(
  parameter logic [PLS_W-1:0] RESET_LS = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_apply,
  input  logic             strobe,
  input  logic [PLS_W-1:0] req_ls,
  output logic [PLS_W-1:0] ls_q,
  output logic             ls_change
);
  logic accept;

  always_comb begin
    accept    = wr_apply && strobe && ls_accept(ls_q, req_ls);
    ls_change = accept && (req_ls == LS_U0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ls_q <= RESET_LS;
    else if (accept) ls_q <= req_ls;
  end

  p_ls_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_apply && strobe)) |=> $stable(ls_q));
  p_u0_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_apply && strobe && req_ls == LS_U0 && ls_q != LS_U0) |=> (ls_q == LS_U0));
  p_u3_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_apply && req_ls == LS_U3 && ls_q >= LS_U3) |=> $stable(ls_q));
  p_other_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_apply && req_ls != LS_U0 && req_ls != LS_U3) |=> $stable(ls_q));
endmodule

// File: rtl/change_flags.sv
module change_flags
  import port_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] sw_clr,
  input  logic [NFLAGS-1:0] set_req,
  output logic [NFLAGS-1:0] flags_q,
  output logic              notify
);
  logic [NFLAGS-1:0] kept;
  logic [NFLAGS-1:0] flags_d;

  always_comb begin
    kept    = flags_q & ~sw_clr;
    flags_d = kept | set_req;
    notify  = fresh_change(set_req, kept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((flags_q & $past(set_req)) == $past(set_req)));
  p_clear_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req == '0) |=> (flags_q == ($past(flags_q) & ~$past(sw_clr))));
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
  import port_status_pkg::*;
#(
  parameter logic [PLS_W-1:0] RESET_LS = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NFLAGS-1:0] hw_set,
  input  logic              run,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req,
  output logic              event_req
);
  logic              rst_write;
  logic              plain_write;
  logic [NFLAGS-1:0] sw_clr;
  logic [NFLAGS-1:0] set_req;
  logic [PLS_W-1:0]  ls_q;
  logic              ls_change;
  logic [NFLAGS-1:0] flags_q;
  logic              notify;
  logic              notify_q;
  logic              pp_q;
  logic [WEN_W-1:0]  wen_q;
  logic              unused_wr;

  assign rst_write   = wr_en && wr_data[PR_BIT];
  assign plain_write = wr_en && !wr_data[PR_BIT];
  assign sw_clr      = plain_write ? wr_data[FLAG_LSB +: NFLAGS] : '0;
  assign unused_wr   = ^{wr_data[DATA_W-1:WEN_LSB+WEN_W], wr_data[WEN_LSB-1:FLAG_LSB+NFLAGS],
                         wr_data[LWS_BIT-1:PP_BIT+1], wr_data[PR_BIT-1:0]};

  always_comb begin
    set_req          = hw_set;
    set_req[PLC_IDX] = hw_set[PLC_IDX] | ls_change;
  end

  link_state_ctl #(.RESET_LS(RESET_LS)) u_ls (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_apply  (plain_write),
    .strobe    (wr_data[LWS_BIT]),
    .req_ls    (wr_data[PLS_LSB +: PLS_W]),
    .ls_q      (ls_q),
    .ls_change (ls_change)
  );

  change_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_clr  (sw_clr),
    .set_req (set_req),
    .flags_q (flags_q),
    .notify  (notify)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_q      <= 1'b0;
      wen_q     <= '0;
      reset_req <= 1'b0;
      notify_q  <= 1'b0;
      event_req <= 1'b0;
    end else begin
      if (plain_write) begin
        pp_q  <= wr_data[PP_BIT];
        wen_q <= wr_data[WEN_LSB +: WEN_W];
      end
      reset_req <= rst_write;
      notify_q  <= notify && run;
      event_req <= notify_q;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[PLS_LSB +: PLS_W]     = ls_q;
    rd_data[PP_BIT]               = pp_q;
    rd_data[FLAG_LSB +: NFLAGS]   = flags_q;
    rd_data[WEN_LSB +: WEN_W]     = wen_q;
  end

  p_reset_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_write |=> reset_req);
  p_reset_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_write |=> ($stable(ls_q) && $stable(pp_q) && $stable(wen_q)));
  p_rw_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_write |=> (pp_q == $past(wr_data[PP_BIT]) && wen_q == $past(wr_data[WEN_LSB +: WEN_W])));
  p_plc_on_u0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ls_change |=> flags_q[PLC_IDX]);
  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ##1 !event_req);
  p_event_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !notify |=> ##1 !event_req);
  p_no_spurious_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_write |=> !reset_req);
endmodule

// File: tb/tb_port_status_reg.sv
module tb_port_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  hw_set = '0;
  logic        run = 1'b1;
  logic [31:0] rd_data;
  logic        reset_req;
  logic        event_req;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  port_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_set(hw_set), .run(run), .rd_data(rd_data),
    .reset_req(reset_req), .event_req(event_req)
  );

  typedef struct packed {
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_rst;
    logic        exp_evt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0000, 32'h0040_0000, 1'b0, 1'b1},  // R4 U0 from 5, link change flag, event
    '{32'h0001_0200, 32'h0040_0200, 1'b0, 1'b0},  // R4 U0 refused in U0; R7 power bit
    '{32'h0001_0260, 32'h0040_0260, 1'b0, 1'b0},  // R5 U3 from 0 accepted
    '{32'h0001_0260, 32'h0040_0260, 1'b0, 1'b0},  // R5 U3 refused from 3
    '{32'h0001_03E0, 32'h0040_0260, 1'b0, 1'b0},  // R6 Resume ignored
    '{32'h0001_02E0, 32'h0040_0260, 1'b0, 1'b0},  // R6 value 7 ignored
    '{32'h0200_0200, 32'h0240_0260, 1'b0, 1'b0},  // R3 U0 without strobe ignored
    '{32'h0840_0000, 32'h0800_0060, 1'b0, 1'b0},  // R2 clear link flag; R7 bits rewritten
    '{32'h0041_0210, 32'h0800_0060, 1'b1, 1'b0},  // R1 reset write freezes all
    '{32'h0001_0000, 32'h0040_0000, 1'b0, 1'b1},  // R4 U0 from 3
    '{32'h0041_0000, 32'h0000_0000, 1'b0, 1'b0}   // R4 refused, R2 clear applied
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic wen, input logic [31:0] wd,
                      input logic [6:0] hs, input logic rn,
                      input logic [31:0] exp_rd, input logic exp_rst, input logic exp_evt);
    @(negedge clk);
    wr_en = wen; wr_data = wd; hw_set = hs; run = rn;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; hw_set = '0;
    check({req, " rd"}, rd_data, exp_rd);
    check({req, " reset_req"}, {31'b0, reset_req}, {31'b0, exp_rst});
    @(negedge clk);
    check({req, " event_req"}, {31'b0, event_req}, {31'b0, exp_evt});
    check({req, " reset_req low"}, {31'b0, reset_req}, 32'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rd", rd_data, 32'h0000_00A0);
    check("R11 outs", {30'b0, reset_req, event_req}, 32'b0);

    for (int i = 0; i < NV; i++)
      step("R3-vec", 1'b1, VECS[i].wdata, 7'h0, 1'b1, VECS[i].exp_rd, VECS[i].exp_rst, VECS[i].exp_evt);

    step("R8 hw set", 1'b0, 32'h0, 7'h01, 1'b1, 32'h0002_0000, 1'b0, 1'b1);
    step("R9 already set", 1'b0, 32'h0, 7'h01, 1'b1, 32'h0002_0000, 1'b0, 1'b0);
    step("R2 write zero", 1'b1, 32'h0, 7'h00, 1'b1, 32'h0002_0000, 1'b0, 1'b0);
    step("R8 set beats clear", 1'b1, 32'h0002_0000, 7'h01, 1'b1, 32'h0002_0000, 1'b0, 1'b1);
    step("R10 stopped", 1'b0, 32'h0, 7'h02, 1'b0, 32'h0006_0000, 1'b0, 1'b0);
    step("R2 clear two", 1'b1, 32'h0006_0000, 7'h00, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
    step("R1 reset with set", 1'b1, 32'h0001_0010, 7'h40, 1'b1, 32'h0080_0000, 1'b1, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule